// File: doc/BRIEF.md
# Word-Serial Multi-Precision Multiplier

This block multiplies two unsigned integers of `OP_W` bits with one `DIG_W` by `DIG_W` multiplier and a handful of `DIG_W`-bit adders. Each operand is cut into `S = OP_W/DIG_W` digits, where digit n holds bits n·DIG_W up to (n+1)·DIG_W−1. The unit walks the digits one pair per clock. Its outer loop steps over the multiplier operand `b` (index i) and its inner loop over the multiplicand `a` (index j). The partial results collect in a buffer of 2S digits, addressed by digit index.

A single step forms t[i+j] + a[j]·b[i] + C. The low digit goes back into t[i+j] and the high digit becomes the new carry C. The step is built from four adds around the multiply. First t[i+j] is added to C. The high half of the product then goes into the resulting carry bit, and this add cannot overflow. The low half is added to the first sum. Finally the carry of that last add joins the carry. Once the inner loop ends, one extra cycle stores the carry in t[i+S] and clears it for the next outer pass. The full product is the concatenation t[2S−1] … t[0].

The controller has four states. IDLE waits for `start_i`. MAC performs one inner step per cycle. WB writes the carry digit. DONE raises the completion pulse. The transitions are: IDLE→MAC on start (operands captured, buffer and carry cleared); MAC→MAC while j < S−1; MAC→WB on the last inner step; WB→MAC while i < S−1; WB→DONE on the last outer pass; DONE→IDLE unconditionally.

Top module: `mpmul_serial`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0 and `product_o` is 0.
- R2: When `done_o` is 1, `product_o` equals the full 2·OP_W-bit unsigned product of the operands captured at the accepted start.
- R3: `done_o` rises exactly S·(S+1) clock edges after the edge that samples an accepted `start_i` (S steps plus one carry-write cycle per outer pass), and it stays high for exactly one cycle.
- R4: `busy_o` is 1 from the cycle after an accepted start through the cycle in which `done_o` is 1, and it is 0 in the cycle that follows.
- R5: A `start_i` pulse while `busy_o` is 1 is ignored: the running product and its completion time are unchanged.
- R6: Operands are captured at the accepted start. Changes on `op_a_i`/`op_b_i` after that edge do not affect the result.
- R7: All 2S result digits are cleared at each accepted start, so no digit of an earlier product leaks into a later one.
- R8: Within a step, neither the add of the high product half into the carry nor the final carry add overflows `DIG_W` bits.
- R9: While idle with no start, `product_o` holds the last completed product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled when idle |
| op_a_i | input | OP_W | Multiplicand |
| op_b_i | input | OP_W | Multiplier |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| product_o | output | 2·OP_W | Result digits t[2S−1]…t[0] |

## Verification
The assertions assume that `start_i` is a clean, synchronous level and that reset is released only between runs. The operand registers are assumed to change only on an accepted start. The bench drives every input on the falling edge and holds `start_i` high for one cycle, either while idle or on purpose in the middle of a run. Every pair of 6-bit operands is swept on a 2-bit digit configuration, and the inputs are scrambled right after each start to show that the design reads only its captured copies.

// File: rtl/mpmul_pkg.sv
package mpmul_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_MAC  = 2'd1,
        S_WB   = 2'd2,
        S_DONE = 2'd3
    } mp_state_t;

    function automatic int unsigned idx_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/mpmul_digit_mac.sv
module mpmul_digit_mac #(
    parameter int DIG_W = 4
) (
    input  logic [DIG_W-1:0] t_i,
    input  logic [DIG_W-1:0] a_i,
    input  logic [DIG_W-1:0] b_i,
    input  logic [DIG_W-1:0] c_i,
    output logic [DIG_W-1:0] s_o,
    output logic [DIG_W-1:0] c_o
);
    logic [DIG_W:0]       sum_tc;
    logic [2*DIG_W-1:0]   prod;
    logic [DIG_W:0]       sum_hc;
    logic [DIG_W:0]       sum_ls;
    logic [DIG_W:0]       sum_cc;

    always_comb begin
        sum_tc = {1'b0, t_i} + {1'b0, c_i};
        prod   = (2*DIG_W)'(a_i) * (2*DIG_W)'(b_i);
        sum_hc = {1'b0, prod[2*DIG_W-1:DIG_W]} + (DIG_W+1)'(sum_tc[DIG_W]);
        sum_ls = {1'b0, sum_tc[DIG_W-1:0]} + {1'b0, prod[DIG_W-1:0]};
        sum_cc = {1'b0, sum_hc[DIG_W-1:0]} + (DIG_W+1)'(sum_ls[DIG_W]);
        s_o    = sum_ls[DIG_W-1:0];
        c_o    = sum_cc[DIG_W-1:0];
    end

    always_comb begin
        AST_HC_NO_OVERFLOW: assert (sum_hc[DIG_W] == 1'b0); // R8
        AST_CC_NO_OVERFLOW: assert (sum_cc[DIG_W] == 1'b0); // R8
    end
endmodule

// File: rtl/mpmul_digit_buf.sv
module mpmul_digit_buf #(
    parameter int DIG_W = 4,
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr_i,
    input  logic                   wr_en_i,
    input  logic [IDX_W-1:0]       wr_idx_i,
    input  logic [DIG_W-1:0]       wr_data_i,
    input  logic [IDX_W-1:0]       rd_idx_i,
    output logic [DIG_W-1:0]       rd_data_o,
    output logic [DEPTH*DIG_W-1:0] flat_o
);
    logic [DIG_W-1:0] dig_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_dig
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dig_q[g] <= '0;
            end else if (clr_i) begin
                dig_q[g] <= '0;
            end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
                dig_q[g] <= wr_data_i;
            end
        end
        assign flat_o[g*DIG_W +: DIG_W] = dig_q[g];
    end

    always_comb begin
        rd_data_o = '0;
        for (int n = 0; n < DEPTH; n++) begin
            if (rd_idx_i == IDX_W'(n)) rd_data_o = dig_q[n];
        end
    end
endmodule

// File: rtl/mpmul_ctrl.sv
module mpmul_ctrl
    import mpmul_pkg::*;
#(
    parameter int DIGITS = 4,
    parameter int IDX_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             load_o,
    output logic             mac_o,
    output logic             wb_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [IDX_W-1:0] i_o,
    output logic [IDX_W-1:0] j_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DIGITS - 1);

    mp_state_t        state_q, state_d;
    logic [IDX_W-1:0] i_q, i_d, j_q, j_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            i_q     <= '0;
            j_q     <= '0;
        end else begin
            state_q <= state_d;
            i_q     <= i_d;
            j_q     <= j_d;
        end
    end

    always_comb begin
        state_d = state_q;
        i_d     = i_q;
        j_d     = j_q;
        load_o  = 1'b0;
        mac_o   = 1'b0;
        wb_o    = 1'b0;
        busy_o  = 1'b1;
        done_o  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                busy_o = 1'b0;
                if (start_i) begin
                    load_o  = 1'b1;
                    i_d     = '0;
                    j_d     = '0;
                    state_d = S_MAC;
                end
            end
            S_MAC: begin
                mac_o = 1'b1;
                if (j_q == LAST) begin
                    state_d = S_WB;
                end else begin
                    j_d = j_q + 1'b1;
                end
            end
            S_WB: begin
                wb_o = 1'b1;
                j_d  = '0;
                if (i_q == LAST) begin
                    state_d = S_DONE;
                end else begin
                    i_d     = i_q + 1'b1;
                    state_d = S_MAC;
                end
            end
            S_DONE: begin
                done_o  = 1'b1;
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    assign i_o = i_q;
    assign j_o = j_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R3
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o); // R4
    AST_DONE_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(wb_o)); // R3
    AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o); // R4
endmodule

// File: rtl/mpmul_serial.sv
module mpmul_serial
    import mpmul_pkg::*;
#(
    parameter int OP_W  = 16,
    parameter int DIG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [OP_W-1:0]   op_a_i,
    input  logic [OP_W-1:0]   op_b_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [2*OP_W-1:0] product_o
);
    localparam int DIGITS  = OP_W / DIG_W;
    localparam int RDIGITS = 2 * DIGITS;
    localparam int IDX_W   = idx_bits(DIGITS);
    localparam int RIDX_W  = idx_bits(RDIGITS);
    localparam logic [RIDX_W-1:0] WB_OFS = RIDX_W'(DIGITS);

    logic [OP_W-1:0]   op_a_q, op_b_q;
    logic [DIG_W-1:0]  carry_q;
    logic              load, mac, wb;
    logic [IDX_W-1:0]  i_idx, j_idx;
    logic [RIDX_W-1:0] rd_idx, wr_idx;
    logic [DIG_W-1:0]  t_dig, a_dig, b_dig, s_new, c_new, wr_data;

    mpmul_ctrl #(.DIGITS(DIGITS), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .load_o(load), .mac_o(mac), .wb_o(wb),
        .busy_o(busy_o), .done_o(done_o),
        .i_o(i_idx), .j_o(j_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_a_q  <= '0;
            op_b_q  <= '0;
            carry_q <= '0;
        end else begin
            if (load) begin
                op_a_q <= op_a_i;
                op_b_q <= op_b_i;
            end
            if (load || wb) carry_q <= '0;
            else if (mac)   carry_q <= c_new;
        end
    end

    assign a_dig   = op_a_q[j_idx*DIG_W +: DIG_W];
    assign b_dig   = op_b_q[i_idx*DIG_W +: DIG_W];
    assign rd_idx  = RIDX_W'(i_idx) + RIDX_W'(j_idx);
    assign wr_idx  = wb ? (RIDX_W'(i_idx) + WB_OFS) : rd_idx;
    assign wr_data = wb ? carry_q : s_new;

    mpmul_digit_mac #(.DIG_W(DIG_W)) u_mac (
        .t_i(t_dig), .a_i(a_dig), .b_i(b_dig), .c_i(carry_q),
        .s_o(s_new), .c_o(c_new)
    );

    mpmul_digit_buf #(.DIG_W(DIG_W), .DEPTH(RDIGITS), .IDX_W(RIDX_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr_i(load),
        .wr_en_i(mac || wb), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
        .rd_idx_i(rd_idx), .rd_data_o(t_dig), .flat_o(product_o)
    );

    AST_OPERANDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($stable(op_a_q) && $stable(op_b_q))); // R5
    AST_IDLE_PRODUCT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(product_o)); // R9
    AST_CLEAR_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (product_o == '0)); // R7
endmodule

// File: tb/mpmul_serial_tb.sv
module mpmul_serial_tb;
    localparam int N = 6;
    localparam int K = 2;
    localparam int S = N / K;
    localparam int W = S * (S + 1);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic [N-1:0]   op_a_i = '0, op_b_i = '0;
    logic           busy_o, done_o;
    logic [2*N-1:0] product_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    mpmul_serial #(.OP_W(N), .DIG_W(K)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .op_a_i(op_a_i), .op_b_i(op_b_i),
        .busy_o(busy_o), .done_o(done_o), .product_o(product_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one run; inject = pulse start with other operands mid-run (R5)
    task automatic run(input logic [N-1:0] a, input logic [N-1:0] b, input bit inject, input bit full);
        int cnt;
        logic [2*N-1:0] exp;
        exp = (2*N)'(a) * (2*N)'(b);
        @(negedge clk);
        op_a_i = a; op_b_i = b; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        op_a_i = ~a; op_b_i = b ^ N'(21);   // R6: scramble after capture
        if (full) check(busy_o === 1'b1, "R4 busy after start", busy_o, 1);
        cnt = 0;
        while (!done_o && cnt < 4 * W) begin
            @(negedge clk);
            cnt++;
            if (inject && cnt == 3) begin
                start_i = 1'b1; op_a_i = N'(5); op_b_i = N'(9);
            end else begin
                start_i = 1'b0;
            end
            if (!done_o && busy_o !== 1'b1) check(1'b0, "R4 busy mid-run", busy_o, 1);
        end
        start_i = 1'b0;
        check(product_o === exp, "R2/R6 product", product_o, exp);
        if (full || inject) check(cnt == W, "R3/R5 latency", cnt, W);
        if (full) check(busy_o === 1'b1, "R4 busy at done", busy_o, 1);
        @(negedge clk);
        if (full) begin
            check(done_o === 1'b0, "R3 done one cycle", done_o, 0);
            check(busy_o === 1'b0, "R4 busy low after done", busy_o, 0);
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        logic [2*N-1:0] held;
        repeat (3) @(negedge clk);
        check(busy_o === 1'b0, "R1 busy reset", busy_o, 0);
        check(done_o === 1'b0, "R1 done reset", done_o, 0);
        check(product_o === '0, "R1 product reset", product_o, 0);
        rst_n = 1'b1;

        run('1, '1, 1'b0, 1'b1);              // all ones, R8 max carries
        run('0, '1, 1'b0, 1'b1);              // zero operand, R7 clears old digits
        check(product_o === '0, "R7 cleared after max", product_o, 0);
        run(N'(1), N'(32), 1'b0, 1'b1);       // single bits
        run(N'(32), N'(32), 1'b0, 1'b1);
        run(N'(45), N'(27), 1'b1, 1'b1);      // R5 start during run

        // R9: hold while idle
        held = product_o;
        op_a_i = '1; op_b_i = '1;
        repeat (20) @(negedge clk);
        check(product_o === held, "R9 idle hold", product_o, held);

        // R2 exhaustive sweep
        for (int x = 0; x < (1 << N); x++) begin
            for (int y = 0; y < (1 << N); y++) begin
                run(N'(x), N'(y), 1'b0, (x == y));
            end
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule